// File: doc/BRIEF.md
# Enhanced-Mode Register Window for a SCSI Bus Controller

This block sits beside the register file of a classic 5380-style SCSI bus controller and opens a second view onto its highest register slot. When a steering bit in the initiator command byte is set, host reads and writes at slot 7 no longer reach the ordinary slot 7 byte. They reach an extended-mode byte instead. A two-bit function field inside that byte then decides what the next access does. It can return a status byte, acknowledge the pending interrupt, start a DMA initiator receive, or load the interrupt mask by an indirect write.

The host side is a plain register port. It has an address, byte write data, separate read and write strobes, and combinational read data. The SCSI bus phase, the end-of-DMA flag and the DMA-mode bit come in as inputs, together with an interrupt event strobe and the global interrupt enable. The block drives the masked interrupt line and a one-cycle DMA start pulse. A controller reset clears the base registers and leaves the interrupt mask intact, because the software that uses the mask sets it once and does not set it again after a bus reset.

Top module: `scsi_xwin_top`

## Requirements
- R1: After power-on reset (rst_n low) every stored byte is zero: reads of slots 0 to 7 return 0x00, irq_out is 0 and dma_start is 0.
- R2: With slot 1 bit 6 clear, a write to any slot 0 to 7 stores the whole byte, and a read of that slot returns it. Slot 1 bit 6 is stored and read back like any other bit.
- R3: With slot 1 bit 6 set, reads and writes at slot 7 go to the extended-mode byte. The ordinary slot 7 byte keeps its value and is seen again once the bit is cleared.
- R4: The function field is bits 2:1 of the extended-mode byte. A read while it holds 3 returns a status byte. Bit 4 of that byte equals the eodma_flag input. Bit 5 is 1 when bus_phase equals slot 3 bits 2:0. All other bits are 0, and the stored byte is not changed.
- R5: A read while the function field is 0, 1 or 2 returns the stored extended-mode byte and then clears bits 2:1, keeping the other bits.
- R6: A write while the stored function field is 3 loads the write data into the interrupt mask and clears bits 2:1 of the extended-mode byte. Its other bits are kept.
- R7: A write while the stored function field is not 3 stores the byte. If the new function field is 1, the pending interrupt is cleared.
- R8: A stored write whose new function field is 2 while dma_mode is 1 raises dma_start for exactly the one cycle after the write. With dma_mode at 0 no pulse is produced.
- R9: irq_out is 1 exactly when an interrupt is pending, irq_glob_en is 1 and interrupt mask bit 5 is 1. irq_event sets the pending flag, and it wins over a clear in the same cycle.
- R10: With slot 1 bit 6 clear, a read of slot 7 clears the pending interrupt.
- R11: ctrl_rst clears slots 0 to 7, the extended-mode byte, the pending flag and any DMA pulse. The interrupt mask keeps its value, and host writes in that cycle are ignored.
- R12: Addresses 8 and above read 0x00 and writes to them change nothing. rdata is 0x00 whenever rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears everything |
| ctrl_rst | input | 1 | Controller reset, synchronous, keeps the interrupt mask |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational |
| bus_phase | input | 3 | Current SCSI bus phase |
| eodma_flag | input | 1 | End-of-DMA flag |
| dma_mode | input | 1 | DMA mode enable bit |
| irq_event | input | 1 | Interrupt source strobe, sets pending |
| irq_glob_en | input | 1 | Global interrupt enable |
| irq_out | output | 1 | Masked interrupt request |
| dma_start | output | 1 | One-cycle DMA initiator receive start |

## Verification
The bench goes after the read side effects. A design that cleared the function field on a status read would lose function 3 before the mask write, and the mask would be written as a normal byte. The bench also checks that a controller reset keeps the mask: a design that wiped it would leave irq_out low for a later interrupt event. The DMA start is tried with dma_mode both high and low, and the bench checks that it lasts one cycle. It also checks that an interrupt event arriving together with an acknowledge leaves the interrupt pending.

// File: rtl/scsi_xwin_pkg.sv
package scsi_xwin_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FN_IDLE = 2'd0,
    FN_ACK  = 2'd1,
    FN_DMA  = 2'd2,
    FN_STAT = 2'd3
  } xw_fn_e;

  function automatic xw_fn_e fn_of(input logic [BYTE_W-1:0] b);
    return xw_fn_e'(b[2:1]);
  endfunction

  function automatic logic [BYTE_W-1:0] fn_clear(input logic [BYTE_W-1:0] b);
    return b & 8'hF9;
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic eodma, input logic match);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[4] = eodma;
    s[5] = match;
    return s;
  endfunction

endpackage

// File: rtl/xw_base_regs.sv
module xw_base_regs
  import scsi_xwin_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ctrl_rst,
  input  logic [NUM_SLOTS-1:0]              wr_sel,
  input  logic [BYTE_W-1:0]                 wdata,
  output logic [NUM_SLOTS-1:0][BYTE_W-1:0]  slot_q
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            slot_q[g] <= '0;
      else if (ctrl_rst)     slot_q[g] <= '0;
      else if (wr_sel[g])    slot_q[g] <= wdata;
    end
  end

  assert_base_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (slot_q == '0));

endmodule

// File: rtl/xw_mode_e.sv
module xw_mode_e
  import scsi_xwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_rst,
  input  logic              e_wr,
  input  logic              e_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dma_mode,
  output logic [BYTE_W-1:0] mode_q,
  output logic              imr_irq_en,
  output logic              ack_clr,
  output logic              dma_start
);

  logic [BYTE_W-1:0] imr_q;
  xw_fn_e            cur_fn;
  xw_fn_e            new_fn;
  logic              mask_load;
  logic              store_wr;
  logic              rd_clear;
  logic              dma_fire;

  assign cur_fn    = fn_of(mode_q);
  assign new_fn    = fn_of(wdata);
  assign mask_load = e_wr && (cur_fn == FN_STAT);
  assign store_wr  = e_wr && (cur_fn != FN_STAT);
  assign rd_clear  = e_rd && !e_wr && (cur_fn != FN_STAT);
  assign ack_clr   = store_wr && (new_fn == FN_ACK);
  assign dma_fire  = store_wr && (new_fn == FN_DMA) && dma_mode;
  assign imr_irq_en = imr_q[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      imr_q     <= '0;
      dma_start <= 1'b0;
    end else if (ctrl_rst) begin
      mode_q    <= '0;
      dma_start <= 1'b0;
    end else begin
      dma_start <= dma_fire;
      if (mask_load) begin
        imr_q  <= wdata;
        mode_q <= fn_clear(mode_q);
      end else if (store_wr) begin
        mode_q <= wdata;
      end else if (rd_clear) begin
        mode_q <= fn_clear(mode_q);
      end
    end
  end

  assert_dma_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  assert_imr_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (imr_q == $past(imr_q)));

  assert_read_clears_fn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rd && !e_wr && !ctrl_rst && (mode_q[2:1] != 2'd3)) |=> (mode_q[2:1] == 2'd0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_wr && !ctrl_rst && (mode_q[2:1] == 2'd3)) |=> (imr_q == $past(wdata)));

endmodule

// File: rtl/xw_irq.sv
module xw_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_rst,
  input  logic irq_event,
  input  logic clr_ack,
  input  logic clr_read,
  input  logic glob_en,
  input  logic mask_en,
  output logic irq_out
);

  logic pend_q;
  logic clr_any;

  assign clr_any = clr_ack || clr_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (ctrl_rst)   pend_q <= 1'b0;
    else if (irq_event)  pend_q <= 1'b1;
    else if (clr_any)    pend_q <= 1'b0;
  end

  assign irq_out = pend_q && glob_en && mask_en;

  assert_clear_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !irq_event && !ctrl_rst) |=> !irq_out);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && !ctrl_rst) |=> pend_q);

endmodule

// File: rtl/scsi_xwin_top.sv
module scsi_xwin_top
  import scsi_xwin_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic [2:0]        bus_phase,
  input  logic              eodma_flag,
  input  logic              dma_mode,
  input  logic              irq_event,
  input  logic              irq_glob_en,
  output logic              irq_out,
  output logic              dma_start
);

  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int CMD_SLOT   = 1;
  localparam int STEER_BIT  = 6;
  localparam int PHASE_SLOT = 3;
  localparam int WIN_SLOT   = NUM_SLOTS - 1;

  logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_q;
  logic [NUM_SLOTS-1:0]             wr_sel;
  logic [SLOT_W-1:0]                sidx;
  logic                             in_range;
  logic                             steer;
  logic                             at_win;
  logic                             hit_win;
  logic                             e_wr;
  logic                             e_rd;
  logic                             plain_wr;
  logic                             norm_win_rd;
  logic [BYTE_W-1:0]                mode_q;
  logic                             imr_irq_en;
  logic                             ack_clr;
  logic                             phase_match;

  assign in_range    = (addr < ADDR_W'(NUM_SLOTS));
  assign sidx        = addr[SLOT_W-1:0];
  assign steer       = slot_q[CMD_SLOT][STEER_BIT];
  assign at_win      = in_range && (sidx == SLOT_W'(WIN_SLOT));
  assign hit_win     = at_win && steer;
  assign e_wr        = wr_en && hit_win && !ctrl_rst;
  assign e_rd        = rd_en && hit_win && !ctrl_rst;
  assign plain_wr    = wr_en && in_range && !hit_win && !ctrl_rst;
  assign norm_win_rd = rd_en && at_win && !steer && !ctrl_rst;
  assign phase_match = (bus_phase == slot_q[PHASE_SLOT][2:0]);

  always_comb begin
    wr_sel = '0;
    if (plain_wr) wr_sel[sidx] = 1'b1;
  end

  xw_base_regs #(.NUM_SLOTS(NUM_SLOTS)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_rst (ctrl_rst),
    .wr_sel   (wr_sel),
    .wdata    (wdata),
    .slot_q   (slot_q)
  );

  xw_mode_e u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rst   (ctrl_rst),
    .e_wr       (e_wr),
    .e_rd       (e_rd),
    .wdata      (wdata),
    .dma_mode   (dma_mode),
    .mode_q     (mode_q),
    .imr_irq_en (imr_irq_en),
    .ack_clr    (ack_clr),
    .dma_start  (dma_start)
  );

  xw_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_rst  (ctrl_rst),
    .irq_event (irq_event),
    .clr_ack   (ack_clr),
    .clr_read  (norm_win_rd),
    .glob_en   (irq_glob_en),
    .mask_en   (imr_irq_en),
    .irq_out   (irq_out)
  );

  always_comb begin
    rdata = '0;
    if (rd_en && in_range) begin
      if (hit_win) begin
        if (fn_of(mode_q) == FN_STAT) rdata = status_byte(eodma_flag, phase_match);
        else                          rdata = mode_q;
      end else begin
        rdata = slot_q[sidx];
      end
    end
  end

  assert_oor_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range && !ctrl_rst) |=> $stable(slot_q));

  assert_win_slot_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_wr || e_rd) |=> (slot_q[WIN_SLOT] == $past(slot_q[WIN_SLOT])));

endmodule

// File: tb/scsi_xwin_top_bench.sv
module scsi_xwin_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_rst = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic [2:0] bus_phase = '0;
  logic       eodma_flag = 1'b0;
  logic       dma_mode = 1'b0;
  logic       irq_event = 1'b0;
  logic       irq_glob_en = 1'b0;
  logic       irq_out;
  logic       dma_start;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // reference state
  logic [7:0] m_slot [8];
  logic [7:0] m_mode = 8'h00;
  logic [7:0] m_imr  = 8'h00;
  bit         m_pend = 0;
  bit         m_dma  = 0;

  always #10 clk = ~clk;

  scsi_xwin_top u_scsi_xwin_top (
    .clk(clk), .rst_n(rst_n), .ctrl_rst(ctrl_rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .bus_phase(bus_phase),
    .eodma_flag(eodma_flag), .dma_mode(dma_mode), .irq_event(irq_event),
    .irq_glob_en(irq_glob_en), .irq_out(irq_out), .dma_start(dma_start)
  );

  function automatic int fnf(input logic [7:0] b);
    return int'(b[2:1]);
  endfunction

  function automatic logic [7:0] exp_rdata();
    logic [7:0] s;
    if (!rd_en || addr >= 8) return 8'h00;
    if (addr == 7 && m_slot[1][6]) begin
      if (fnf(m_mode) == 3) begin
        s = 8'h00;
        if (eodma_flag) s = s | 8'h10;
        if (bus_phase == m_slot[3][2:0]) s = s | 8'h20;
        return s;
      end
      return m_mode;
    end
    return m_slot[addr[2:0]];
  endfunction

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit redir, win, clr;
    logic [7:0] old_mode;
    if (!rst_n) return;
    if (ctrl_rst) begin
      for (int i = 0; i < 8; i++) m_slot[i] = 8'h00;
      m_mode = 8'h00; m_pend = 0; m_dma = 0;
      return;
    end
    redir = m_slot[1][6];
    win = (addr == 7) && redir;
    old_mode = m_mode;
    clr = 0;
    m_dma = 0;
    if (wr_en && addr < 8 && win) begin
      if (fnf(old_mode) == 3) begin
        m_imr = wdata;
        m_mode = old_mode & 8'hF9;
      end else begin
        m_mode = wdata;
        if (fnf(wdata) == 1) clr = 1;
        if (fnf(wdata) == 2 && dma_mode) m_dma = 1;
      end
    end else if (wr_en && addr < 8) begin
      m_slot[addr[2:0]] = wdata;
    end
    if (rd_en && !wr_en && win && fnf(old_mode) != 3) m_mode = old_mode & 8'hF9;
    if (rd_en && addr == 7 && !redir) clr = 1;
    if (irq_event) m_pend = 1;
    else if (clr) m_pend = 0;
  endtask

  // one clock: inputs set after the falling edge, outputs compared before the rising edge
  task automatic cyc(input logic [3:0] a, input bit w, input bit r, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    #5;
    check("rdata", rdata, exp_rdata());
    check("irq_out", {7'b0, irq_out}, {7'b0, m_pend && irq_glob_en && m_imr[5]});
    check("dma_start", {7'b0, dma_start}, {7'b0, m_dma});
    @(posedge clk);
    model_edge();
    #1;
    irq_event = 1'b0;
    ctrl_rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(a, 1, 0, d);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(a, 0, 1, 8'h00);
  endtask

  task automatic idle();
    cyc(4'd0, 0, 0, 8'h00);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) m_slot[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    for (int i = 0; i < 8; i++) rd(4'(i));

    // R2 plain storage
    tag = "R2";
    for (int i = 0; i < 8; i++) wr(4'(i), 8'h11 * 8'(i + 1) ^ 8'h80);
    for (int i = 0; i < 8; i++) rd(4'(i));
    wr(4'd1, 8'h40); rd(4'd1); wr(4'd1, 8'h00); rd(4'd1);

    // R3 steering into the extended byte
    tag = "R3";
    wr(4'd1, 8'h40); rd(4'd7);
    wr(4'd7, 8'h10); rd(4'd7);
    wr(4'd1, 8'h00); rd(4'd7);
    wr(4'd1, 8'h40);

    // R4 status read
    tag = "R4";
    wr(4'd3, 8'h05);
    wr(4'd7, 8'h06);
    bus_phase = 3'd5; eodma_flag = 1'b1; rd(4'd7);
    bus_phase = 3'd2; eodma_flag = 1'b0; rd(4'd7);
    bus_phase = 3'd5; rd(4'd7);
    bus_phase = 3'd1; eodma_flag = 1'b1; rd(4'd7);

    // R6 indirect mask load, then R9 gating
    tag = "R6";
    wr(4'd7, 8'hA5); rd(4'd7);
    tag = "R9";
    irq_glob_en = 1'b1; irq_event = 1'b1; idle(); idle();
    irq_glob_en = 1'b0; idle(); irq_glob_en = 1'b1; idle();

    // R7 acknowledge through function 1
    tag = "R7";
    wr(4'd7, 8'h02); idle();
    irq_event = 1'b1; idle();
    tag = "R9";
    irq_event = 1'b1; wr(4'd7, 8'h02); idle();
    tag = "R7";
    wr(4'd7, 8'h02); idle();

    // R8 DMA start
    tag = "R8";
    dma_mode = 1'b1; wr(4'd7, 8'h04); idle(); idle();
    dma_mode = 1'b0; wr(4'd7, 8'h04); idle();

    // R5 read clears function field
    tag = "R5";
    dma_mode = 1'b1; wr(4'd7, 8'h8C); rd(4'd7); rd(4'd7);
    wr(4'd7, 8'h7A); rd(4'd7); rd(4'd7);
    dma_mode = 1'b0;

    // mask bit 5 cleared blocks irq (R9)
    tag = "R9";
    wr(4'd7, 8'h06); wr(4'd7, 8'h00);
    irq_event = 1'b1; idle(); idle();
    wr(4'd7, 8'h06); wr(4'd7, 8'h20); idle();

    // R10 plain slot 7 read acknowledges
    tag = "R10";
    wr(4'd1, 8'h00); irq_event = 1'b1; idle();
    rd(4'd7); idle();

    // R11 controller reset keeps the mask
    tag = "R11";
    wr(4'd2, 8'h33); irq_event = 1'b1; idle();
    ctrl_rst = 1'b1; wr(4'd4, 8'hEE);
    for (int i = 0; i < 8; i++) rd(4'(i));
    irq_event = 1'b1; idle(); idle();
    wr(4'd1, 8'h40); rd(4'd7);

    // R12 out-of-range addresses
    tag = "R12";
    wr(4'd9, 8'hFF); wr(4'd15, 8'h77);
    rd(4'd8); rd(4'd12); rd(4'd1); rd(4'd7);
    cyc(4'd1, 0, 0, 8'h00);

    // mixed traffic against the model
    tag = "R2";
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_phase = lfsr[2:0];
      eodma_flag = lfsr[3];
      dma_mode = lfsr[4];
      irq_event = (lfsr[7:5] == 3'd0);
      irq_glob_en = lfsr[8];
      ctrl_rst = (lfsr[15:11] == 5'd3);
      cyc(lfsr[12:9], lfsr[13], lfsr[14], lfsr[7:0] ^ lfsr[15:8]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule